// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is a first-in first-out store with a producer side clocked by `wr_clk` and a consumer side clocked by `rd_clk`. The two clocks may be unrelated or identical. Each side moves one word on a rising edge of its own clock, and only when its select is low and its enable is high. The write pointer and the read pointer cross between the clock domains as gray code through two-flop synchronizers. Every flag is computed in the domain that reads it.

The static input `fwft` picks one of two timing modes. With `fwft` low (standard mode), a read edge returns the word on `rd_data` after that edge. The status outputs then mean "full" on the write side and "empty" on the read side. With `fwft` high (fall-through mode), the oldest word moves into the output register by itself. The status outputs then mean "space available" and "output word valid". The output register holds one extra word, so in this mode the block stores DEPTH+1 words.

Back-pressure works through the status pins. A write attempted when there is no room is dropped. A read attempted when there is no data is dropped, and `rd_data` keeps its value. The two almost flags are active low. Each compares its count against an offset supplied on an input port, and the comparison is inclusive.

Top module: `dcf_top`

## Requirements
- R1: After reset the FIFO is empty. In standard mode `wr_stat`=0 and `rd_stat`=1. In fall-through mode `wr_stat`=1 and `rd_stat`=0. `wr_afull_n`=1 and `rd_aempty_n`=0 (for `afull_ofs` < DEPTH).
- R2: A port transfers a word only on a rising edge of its clock while its `*_cs_n` is 0 and its `*_en` is 1. In any other case the FIFO contents and `rd_data` do not change.
- R3: Words leave in the order they were accepted, with their values intact.
- R4: In standard mode `wr_stat` is 1 exactly when the write side counts DEPTH stored words. A write at that time is dropped.
- R5: In standard mode `rd_stat` is 1 exactly when the read side sees no stored word. A read at that time is dropped and `rd_data` holds.
- R6: In standard mode an accepted read places the word on `rd_data` right after the same `rd_clk` edge.
- R7: In fall-through mode the oldest word appears on `rd_data` with `rd_stat`=1 and no read request. The word and the flag hold until an accepted read. That read advances `rd_data` to the next word, or drops `rd_stat` to 0 if no word is left.
- R8: In fall-through mode `wr_stat` is 1 while a write can be accepted. The output register adds one word, so DEPTH+1 words fit.
- R9: `wr_afull_n` is 0 exactly when (DEPTH minus the write-side count) <= `afull_ofs`.
- R10: `rd_aempty_n` is 0 exactly when the read-side count <= `aempty_ofs`. In fall-through mode the read-side count includes a valid word in the output register.
- R11: Pointers cross as gray code that changes by at most one bit per edge. Once one side stops moving, the other side's flags reflect the transfers within 4 of its own clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low master reset for both domains |
| fwft | input | 1 | Timing mode, 0 standard, 1 fall-through; static after reset |
| wr_clk | input | 1 | Write-side clock |
| wr_cs_n | input | 1 | Write-side select, active low |
| wr_en | input | 1 | Write enable |
| wr_data | input | WIDTH | Word to store |
| afull_ofs | input | AW+1 | Almost-full offset |
| wr_stat | output | 1 | Full (standard) or space-available (fall-through) |
| wr_afull_n | output | 1 | Almost-full flag, active low |
| rd_clk | input | 1 | Read-side clock |
| rd_cs_n | input | 1 | Read-side select, active low |
| rd_en | input | 1 | Read enable |
| aempty_ofs | input | AW+1 | Almost-empty offset |
| rd_data | output | WIDTH | Output word register |
| rd_stat | output | 1 | Empty (standard) or output-valid (fall-through) |
| rd_aempty_n | output | 1 | Almost-empty flag, active low |

## Verification
The bench fills the store to its exact capacity in each mode and then pushes one more write. A design that let that write through would return an unexpected word or never report empty. It walks the almost flags across the boundary count and one count past it on both sides. An off-by-one in either inclusive comparison shows up as a wrong flag at one step. In fall-through mode it checks that the first word arrives without a read and stays through select-only and enable-only cycles. It also checks that capacity is DEPTH+1. A design that advanced the output on a partial request, or did not count the output register, would skip a word or report no space one write early.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } dcf_mode_e;
endpackage

// File: rtl/dcf_gray2bin.sv
module dcf_gray2bin #(
  parameter int W = 12
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  always_comb begin
    bin[W-1] = gray[W-1];
    for (int i = W - 2; i >= 0; i--) bin[i] = bin[i+1] ^ gray[i];
  end
endmodule

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int WIDTH = 36,
  parameter int AW    = 11
) (
  input  logic             wr_clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int DEPTH = 2048,
  parameter int AW    = 11,
  parameter int PW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          en,
  input  logic          fwft,
  input  logic [PW-1:0] rgray_s,
  input  logic [PW-1:0] afull_ofs,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] wgray,
  output logic [AW-1:0] waddr,
  output logic          we,
  output logic          full,
  output logic          stat,
  output logic          afull_n
);
  logic [PW-1:0] rbin, used, free, wnext;

  dcf_gray2bin #(.W(PW)) u_g2b (.gray(rgray_s), .bin(rbin));

  always_comb begin
    used    = wptr - rbin;
    free    = PW'(DEPTH) - used;
    full    = (used == PW'(DEPTH));
    we      = !cs_n && en && !full;
    stat    = fwft ? !full : full;
    afull_n = !(free <= afull_ofs);
    waddr   = wptr[AW-1:0];
    wnext   = wptr + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
    end else if (we) begin
      wptr  <= wnext;
      wgray <= wnext ^ (wnext >> 1);
    end
  end
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
  parameter int AW = 11,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          en,
  input  logic          fwft,
  input  logic [PW-1:0] wgray_s,
  input  logic [PW-1:0] aempty_ofs,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] rgray,
  output logic [AW-1:0] raddr,
  output logic          re,
  output logic          mem_empty,
  output logic          stat,
  output logic          aempty_n
);
  localparam int CW = PW + 1;
  logic [PW-1:0] wbin, avail, rnext;
  logic [CW-1:0] count;
  logic          take, ov;

  dcf_gray2bin #(.W(PW)) u_g2b (.gray(wgray_s), .bin(wbin));

  always_comb begin
    avail     = wbin - rptr;
    mem_empty = (avail == '0);
    take      = !cs_n && en;
    if (fwft) re = !mem_empty && (!ov || take);
    else      re = take && !mem_empty;
    count     = {1'b0, avail} + CW'(ov);
    stat      = fwft ? ov : mem_empty;
    aempty_n  = !(count <= {1'b0, aempty_ofs});
    raddr     = rptr[AW-1:0];
    rnext     = rptr + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      rgray <= '0;
      ov    <= 1'b0;
    end else begin
      if (re) begin
        rptr  <= rnext;
        rgray <= rnext ^ (rnext >> 1);
      end
      if (!fwft)     ov <= 1'b0;
      else if (re)   ov <= 1'b1;
      else if (take) ov <= 1'b0;
    end
  end
endmodule

// File: rtl/dcf_top.sv
module dcf_top #(
  parameter int DEPTH = 2048,
  parameter int WIDTH = 36,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             rst_n,
  input  logic             fwft,
  input  logic             wr_clk,
  input  logic             wr_cs_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [PW-1:0]    afull_ofs,
  output logic             wr_stat,
  output logic             wr_afull_n,
  input  logic             rd_clk,
  input  logic             rd_cs_n,
  input  logic             rd_en,
  input  logic [PW-1:0]    aempty_ofs,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_stat,
  output logic             rd_aempty_n
);
  import dcf_pkg::*;

  dcf_mode_e     mode;
  logic [PW-1:0] w_ptr, w_gray, r_ptr, r_gray, w_gray_s, r_gray_s;
  logic [AW-1:0] w_addr, r_addr;
  logic          w_we, w_full, r_re, r_mem_empty;

  assign mode = dcf_mode_e'(fwft);

  dcf_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .cs_n(wr_cs_n), .en(wr_en),
    .fwft(mode == MODE_FWFT), .rgray_s(r_gray_s), .afull_ofs(afull_ofs),
    .wptr(w_ptr), .wgray(w_gray), .waddr(w_addr), .we(w_we),
    .full(w_full), .stat(wr_stat), .afull_n(wr_afull_n)
  );

  dcf_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(r_gray), .q(r_gray_s));
  dcf_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(w_gray), .q(w_gray_s));

  dcf_rd_ctl #(.AW(AW), .PW(PW)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .cs_n(rd_cs_n), .en(rd_en),
    .fwft(mode == MODE_FWFT), .wgray_s(w_gray_s), .aempty_ofs(aempty_ofs),
    .rptr(r_ptr), .rgray(r_gray), .raddr(r_addr), .re(r_re),
    .mem_empty(r_mem_empty), .stat(rd_stat), .aempty_n(rd_aempty_n)
  );

  dcf_mem #(.WIDTH(WIDTH), .AW(AW)) u_mem (
    .wr_clk(wr_clk), .we(w_we), .waddr(w_addr), .wdata(wr_data),
    .rd_clk(rd_clk), .rst_n(rst_n), .re(r_re), .raddr(r_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
  parameter int PW = 12,
  parameter int W  = 36
) (
  input logic          rst_n,
  input logic          fwft,
  input logic          wr_clk,
  input logic          wr_cs_n,
  input logic          wr_en,
  input logic          rd_clk,
  input logic          rd_cs_n,
  input logic          rd_en,
  input logic          w_full,
  input logic [PW-1:0] w_ptr,
  input logic [PW-1:0] w_gray,
  input logic [PW-1:0] r_ptr,
  input logic [PW-1:0] r_gray,
  input logic          r_mem_empty,
  input logic          rd_stat,
  input logic [W-1:0]  rd_data,
  input logic          wr_afull_n,
  input logic          rd_aempty_n
);
  assert_no_overflow_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (w_full && !wr_cs_n && wr_en) |=> (w_ptr == $past(w_ptr)));

  assert_no_underflow_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!fwft && r_mem_empty && !rd_cs_n && rd_en) |=> ((r_ptr == $past(r_ptr)) && $stable(rd_data)));

  assert_idle_write_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_cs_n || !wr_en) |=> $stable(w_ptr));

  assert_wgray_step_R11: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(w_gray ^ $past(w_gray)) <= 1);

  assert_rgray_step_R11: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(r_gray ^ $past(r_gray)) <= 1);

  assert_full_afull_R9: assert property (@(posedge wr_clk) disable iff (!rst_n)
    w_full |-> !wr_afull_n);

  assert_empty_aempty_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (fwft ? !rd_stat : rd_stat) |-> !rd_aempty_n);

  assert_fwft_hold_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (fwft && rd_stat && (rd_cs_n || !rd_en)) |=> (rd_stat && $stable(rd_data)));
endmodule

bind dcf_top dcf_checker #(.PW(PW), .W(WIDTH)) u_chk (
  .rst_n(rst_n), .fwft(fwft), .wr_clk(wr_clk), .wr_cs_n(wr_cs_n), .wr_en(wr_en),
  .rd_clk(rd_clk), .rd_cs_n(rd_cs_n), .rd_en(rd_en), .w_full(w_full),
  .w_ptr(w_ptr), .w_gray(w_gray), .r_ptr(r_ptr), .r_gray(r_gray),
  .r_mem_empty(r_mem_empty), .rd_stat(rd_stat), .rd_data(rd_data),
  .wr_afull_n(wr_afull_n), .rd_aempty_n(rd_aempty_n)
);

// File: tb/sim_dcf_top.sv
`timescale 1ns/1ps
module sim_dcf_top;
  localparam int DEPTH = 16;
  localparam int WIDTH = 36;
  localparam int PW    = 5;
  localparam int XOFS  = 3;
  localparam int YOFS  = 4;

  logic rst_n = 1'b0, fwft = 1'b0;
  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_cs_n = 1'b1, wr_en = 1'b0, rd_cs_n = 1'b1, rd_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic wr_stat, wr_afull_n, rd_stat, rd_aempty_n;

  int total = 0, fails = 0;
  bit done = 1'b0;
  logic [WIDTH-1:0] exp_q[$];
  logic [WIDTH-1:0] obs_q[$];

  always #2 wr_clk = ~wr_clk;
  always #3 rd_clk = ~rd_clk;

  dcf_top #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .rst_n(rst_n), .fwft(fwft),
    .wr_clk(wr_clk), .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wr_data(wr_data),
    .afull_ofs(PW'(YOFS)), .wr_stat(wr_stat), .wr_afull_n(wr_afull_n),
    .rd_clk(rd_clk), .rd_cs_n(rd_cs_n), .rd_en(rd_en), .aempty_ofs(PW'(XOFS)),
    .rd_data(rd_data), .rd_stat(rd_stat), .rd_aempty_n(rd_aempty_n)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compares each observed output word with the scoreboard head (R3)
  initial forever begin
    @(negedge rd_clk);
    while (obs_q.size() != 0) begin
      logic [WIDTH-1:0] o, e;
      o = obs_q.pop_front();
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected word", 64'(o), 64'h0);
      else begin
        e = exp_q.pop_front();
        chk(o == e, "R3 order/data", 64'(o), 64'(e));
      end
    end
  end

  task automatic do_reset(input logic mode);
    rst_n = 1'b0;
    fwft  = mode;
    exp_q.delete();
    obs_q.delete();
    repeat (4) @(posedge rd_clk);
    @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (3) @(posedge rd_clk);
    #1;
  endtask

  task automatic wr(input logic [WIDTH-1:0] d, input bit accept);
    @(negedge wr_clk);
    wr_cs_n = 1'b0; wr_en = 1'b1; wr_data = d;
    @(posedge wr_clk);
    #1;
    wr_cs_n = 1'b1; wr_en = 1'b0;
    if (accept) exp_q.push_back(d);
  endtask

  task automatic rd(input bit accept);
    logic [WIDTH-1:0] v;
    @(negedge rd_clk);
    v = rd_data;
    rd_cs_n = 1'b0; rd_en = 1'b1;
    @(posedge rd_clk);
    #1;
    rd_cs_n = 1'b1; rd_en = 1'b0;
    if (accept) begin
      if (!fwft) v = rd_data;
      obs_q.push_back(v);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [WIDTH-1:0] held;
    // ---------------- standard mode ----------------
    do_reset(1'b0);
    chk(wr_stat == 1'b0, "R1 std wr_stat", 64'(wr_stat), 64'd0);
    chk(rd_stat == 1'b1, "R1 std rd_stat", 64'(rd_stat), 64'd1);
    chk(wr_afull_n == 1'b1, "R1 afull_n", 64'(wr_afull_n), 64'd1);
    chk(rd_aempty_n == 1'b0, "R1 aempty_n", 64'(rd_aempty_n), 64'd0);

    // R2: select without enable, enable without select
    @(negedge wr_clk); wr_cs_n = 1'b0; wr_en = 1'b0; wr_data = 36'hAAA;
    @(negedge wr_clk); wr_cs_n = 1'b1; wr_en = 1'b1;
    @(negedge wr_clk); wr_en = 1'b0;
    repeat (5) @(posedge rd_clk); #1;
    chk(rd_stat == 1'b1, "R2 no write taken", 64'(rd_stat), 64'd1);

    wr(36'h100, 1'b1);
    repeat (4) @(posedge rd_clk); #1;
    chk(rd_stat == 1'b0, "R11 empty clears within 4 rd clocks", 64'(rd_stat), 64'd0);
    chk(rd_aempty_n == 1'b0, "R10 count 1", 64'(rd_aempty_n), 64'd0);

    for (int n = 2; n <= DEPTH; n++) begin
      wr(36'h100 + 36'(n) * 36'h111, 1'b1);
      chk(wr_afull_n == ((DEPTH - n) > YOFS), "R9 afull step", 64'(wr_afull_n), 64'((DEPTH - n) > YOFS));
      chk(wr_stat == (n == DEPTH), "R4 full flag", 64'(wr_stat), 64'(n == DEPTH));
    end
    wr(36'hBAD, 1'b0);
    chk(wr_stat == 1'b1, "R4 still full", 64'(wr_stat), 64'd1);

    repeat (6) @(posedge rd_clk); #1;
    chk(rd_aempty_n == 1'b1, "R10 count 16", 64'(rd_aempty_n), 64'd1);
    for (int k = 1; k <= DEPTH; k++) begin
      rd(1'b1);
      chk(rd_aempty_n == ((DEPTH - k) > XOFS), "R10 aempty step", 64'(rd_aempty_n), 64'((DEPTH - k) > XOFS));
      chk(rd_stat == (k == DEPTH), "R5 R6 empty flag", 64'(rd_stat), 64'(k == DEPTH));
    end
    held = rd_data;
    rd(1'b0);
    chk(rd_data == held, "R5 data holds on empty read", 64'(rd_data), 64'(held));
    chk(rd_stat == 1'b1, "R4 R5 dropped word absent", 64'(rd_stat), 64'd1);
    repeat (5) @(posedge wr_clk); #1;
    chk(wr_stat == 1'b0, "R11 full clears", 64'(wr_stat), 64'd0);
    chk(wr_afull_n == 1'b1, "R11 afull clears", 64'(wr_afull_n), 64'd1);
    repeat (3) @(posedge rd_clk);
    chk(exp_q.size() == 0, "R3 std scoreboard drained", 64'(exp_q.size()), 64'd0);

    // ---------------- fall-through mode ----------------
    do_reset(1'b1);
    chk(wr_stat == 1'b1, "R1 fwft wr_stat", 64'(wr_stat), 64'd1);
    chk(rd_stat == 1'b0, "R1 fwft rd_stat", 64'(rd_stat), 64'd0);
    wr(36'h5A0, 1'b1);
    repeat (10) @(posedge wr_clk); #1;
    chk(rd_stat == 1'b1, "R7 word falls through", 64'(rd_stat), 64'd1);
    chk(rd_data == 36'h5A0, "R7 first word shown", 64'(rd_data), 64'h5A0);
    chk(rd_aempty_n == 1'b0, "R10 fwft count 1", 64'(rd_aempty_n), 64'd0);

    // R2: partial read requests must not consume the output word
    @(negedge rd_clk); rd_cs_n = 1'b0; rd_en = 1'b0;
    @(negedge rd_clk); rd_cs_n = 1'b1; rd_en = 1'b1;
    @(negedge rd_clk); rd_en = 1'b0;
    chk(rd_data == 36'h5A0, "R2 R7 word held", 64'(rd_data), 64'h5A0);
    chk(rd_stat == 1'b1, "R2 R7 flag held", 64'(rd_stat), 64'd1);

    for (int n = 2; n <= DEPTH + 1; n++) begin
      wr(36'h5A0 + 36'(n) * 36'h0F1, 1'b1);
      chk(wr_stat == (n <= DEPTH), "R8 space flag", 64'(wr_stat), 64'(n <= DEPTH));
    end
    wr(36'hBAD, 1'b0);
    repeat (6) @(posedge rd_clk); #1;
    chk(rd_aempty_n == 1'b1, "R10 fwft count 17", 64'(rd_aempty_n), 64'd1);
    for (int k = 1; k <= DEPTH + 1; k++) begin
      rd(1'b1);
      chk(rd_aempty_n == ((DEPTH + 1 - k) > XOFS), "R10 fwft aempty step",
          64'(rd_aempty_n), 64'((DEPTH + 1 - k) > XOFS));
      chk(rd_stat == (k <= DEPTH), "R7 valid flag", 64'(rd_stat), 64'(k <= DEPTH));
    end
    repeat (5) @(posedge wr_clk); #1;
    chk(wr_stat == 1'b1, "R8 space returns", 64'(wr_stat), 64'd1);
    repeat (3) @(posedge rd_clk);
    chk(exp_q.size() == 0, "R3 fwft scoreboard drained", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    finish_run();
  end
endmodule